// File: doc/BRIEF.md
# Strobed Dual Parallel Port Controller

This block drives two byte-wide parallel ports, A and B, and is programmed through a small register bus with separate read and write strobes. Each port is set up as a whole through one configuration byte. That byte selects the direction (input or output), the output drive (push-pull or open-drain) and the strobe polarity. Each port also has a bidirectional strobe line, modelled as an input, an output value and an output enable.

In output mode the port's data latch drives the pins. Every bus write to that latch emits a one-clock pulse on the port's strobe line. In input mode the strobe line is an input. It passes through a two-flop synchronizer, and its synchronized value is XORed with the polarity bit. The rising edge of that result latches the pins and raises the port's interrupt request flag. A single configuration bit selects how the flags are cleared: either by reading the port's data latch, or by writing ones to the status register. Pin registers return the live pin levels in either direction. This allows an open-drain port to serve as a mixed input/output port.

Each port holds two small state machines:
- **Strobe pulse machine.** State `OP_IDLE` moves to `OP_PULSE` on a latch write in output mode. `OP_PULSE` stays in `OP_PULSE` on a back-to-back write and otherwise returns to `OP_IDLE`.
- **Input edge machine.** State `IE_LOW` moves to `IE_HIGH` when the gated strobe level rises; this transition is the capture event. `IE_HIGH` returns to `IE_LOW` when the level falls.

The gated level is forced low in output mode. For that reason, a change to a direction or polarity bit can itself produce a capture.

Top module: `strobed_pio`

## Requirements
- R1: Register addresses are: 0 configuration, 1 interrupt enable (bit 0 = A, bit 1 = B), 2 status (bit 0 = A flag, bit 1 = B flag), 3 latch A, 4 latch B, 5 pins A, 6 pins B. The configuration bits are: 7 clear mode, 6 reserved, 5 A open-drain, 4 B open-drain, 3 A direction, 2 B direction, 1 A polarity, 0 B polarity. The configuration register resets to 0, and bit 6 always reads 0.
- R2: Output mode (direction 1) with push-pull drive (open-drain bit 0): the output enables are all 1 and the pin outputs equal the latch.
- R3: Output mode with open-drain drive (open-drain bit 1): the pin outputs are 0 and each output enable is the inverse of its latch bit.
- R4: Input mode (direction 0): the pin output enables and the strobe output enable are 0.
- R5: In output mode, a write to the port's latch produces a strobe pulse that is active for exactly the next clock cycle. The active level is high when the polarity bit is 1 and low when it is 0.
- R6: In input mode, the latch captures the pins on a rising edge of (synchronized strobe XOR polarity). The capture lands on the third clock edge after the strobe input changes; at other times the latch holds.
- R7: Reading a pin register returns the current pin inputs, whatever the direction.
- R8: A capture sets the port's flag. The `irq` output is the OR of the flags whose enable bits are set.
- R9: With clear mode 0, reading a port's latch clears that port's flag, and writes to the status register have no effect.
- R10: With clear mode 1, writing the status register clears each flag whose data bit is 1, and reading a latch does not clear the flag.
- R11: In input mode, a change to a polarity or direction bit that makes the gated strobe level rise causes a capture and sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read has side effects at the clock edge) |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |
| pa_in | input | DW | Port A pin levels |
| pa_out | output | DW | Port A pin output values |
| pa_oe | output | DW | Port A per-pin output enables |
| sa_in | input | 1 | Strobe A pin level |
| sa_out | output | 1 | Strobe A output value |
| sa_oe | output | 1 | Strobe A output enable |
| pb_in | input | DW | Port B pin levels |
| pb_out | output | DW | Port B pin output values |
| pb_oe | output | DW | Port B per-pin output enables |
| sb_in | input | 1 | Strobe B pin level |
| sb_out | output | 1 | Strobe B output value |
| sb_oe | output | 1 | Strobe B output enable |

## Verification
The assertions check properties of port A on every cycle:
- the drive pattern in each direction and drive mode;
- every active strobe cycle is preceded by a latch write;
- a rising flag comes with a latch that holds the pins from the previous cycle;
- a falling flag matches the clear event chosen by the clear-mode bit.

Only the bench scenarios can show the other behaviours:
- the three-edge capture latency;
- pulse length and level under both polarities;
- flag clears being ignored in the wrong mode;
- enable masking of `irq`;
- captures caused by rewriting the polarity or direction bits.

// File: rtl/spio_pkg.sv
package spio_pkg;
    localparam int REG_AW      = 3;
    localparam int CFG_W       = 8;
    localparam int NPORT       = 2;
    localparam int SYNC_STAGES = 2;

    localparam int CFG_CLRMODE = 7;
    localparam int CFG_OD_A    = 5;
    localparam int CFG_OD_B    = 4;
    localparam int CFG_DIR_A   = 3;
    localparam int CFG_DIR_B   = 2;
    localparam int CFG_POL_A   = 1;
    localparam int CFG_POL_B   = 0;
    localparam logic [CFG_W-1:0] CFG_MASK = 8'hBF;

    localparam logic [REG_AW-1:0] RA_CFG   = 3'd0;
    localparam logic [REG_AW-1:0] RA_IEN   = 3'd1;
    localparam logic [REG_AW-1:0] RA_STAT  = 3'd2;
    localparam logic [REG_AW-1:0] RA_LAT_A = 3'd3;
    localparam logic [REG_AW-1:0] RA_LAT_B = 3'd4;
    localparam logic [REG_AW-1:0] RA_PIN_A = 3'd5;
    localparam logic [REG_AW-1:0] RA_PIN_B = 3'd6;

    typedef enum logic {OP_IDLE, OP_PULSE} opulse_e;
    typedef enum logic {IE_LOW, IE_HIGH} iedge_e;

    typedef struct packed {
        logic dir;
        logic od;
        logic pol;
    } port_cfg_t;
endpackage

// File: rtl/spio_sync.sv
module spio_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spio_port.sv
module spio_port
    import spio_pkg::*;
#(
    parameter int DW = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  port_cfg_t     cfg,
    input  logic          wr_lat,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_i,
    input  logic          stb_i,
    output logic [DW-1:0] lat_q,
    output logic [DW-1:0] pin_o,
    output logic [DW-1:0] pin_oe,
    output logic          stb_o,
    output logic          stb_oe,
    output logic          cap_o
);
    logic    stb_s;
    logic    lvl;
    logic    cap;
    logic    pulse;
    iedge_e  ie_q, ie_d;
    opulse_e op_q, op_d;

    spio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stb_i),
        .q     (stb_s)
    );

    // Gated strobe level: forced low in output mode.
    assign lvl = ~cfg.dir & (stb_s ^ cfg.pol);

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= IE_LOW;
            op_q <= OP_IDLE;
        end else begin
            ie_q <= ie_d;
            op_q <= op_d;
        end
    end

    // Input edge machine
    always_comb begin
        ie_d = ie_q;
        cap  = 1'b0;
        unique case (ie_q)
            IE_LOW: begin
                if (lvl) begin
                    ie_d = IE_HIGH;
                    cap  = 1'b1;
                end
            end
            IE_HIGH: begin
                if (!lvl) ie_d = IE_LOW;
            end
        endcase
    end

    // Strobe pulse machine
    always_comb begin
        op_d = op_q;
        unique case (op_q)
            OP_IDLE: begin
                if (wr_lat && cfg.dir) op_d = OP_PULSE;
            end
            OP_PULSE: begin
                if (!(wr_lat && cfg.dir)) op_d = OP_IDLE;
            end
        endcase
    end

    // Data latch: capture wins over a bus write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= '0;
        else if (cap)    lat_q <= pin_i;
        else if (wr_lat) lat_q <= wdata;
    end

    // Outputs
    always_comb begin
        pulse  = (op_q == OP_PULSE);
        stb_o  = cfg.pol ? pulse : ~pulse;
        stb_oe = cfg.dir;
        cap_o  = cap;
        if (!cfg.dir) begin
            pin_o  = '0;
            pin_oe = '0;
        end else if (cfg.od) begin
            pin_o  = '0;
            pin_oe = ~lat_q;
        end else begin
            pin_o  = lat_q;
            pin_oe = '1;
        end
    end
endmodule

// File: rtl/spio_irq.sv
module spio_irq #(
    parameter int NP = 2
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_mode,
    input  logic [NP-1:0] set,
    input  logic [NP-1:0] clr_rd,
    input  logic [NP-1:0] clr_wr,
    input  logic [NP-1:0] ien,
    output logic [NP-1:0] flags,
    output logic          irq
);
    for (genvar g = 0; g < NP; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (set[g])
                flags[g] <= 1'b1;
            else if (clr_mode ? clr_wr[g] : clr_rd[g])
                flags[g] <= 1'b0;
        end
    end

    assign irq = |(flags & ien);
endmodule

// File: rtl/strobed_pio.sv
module strobed_pio
    import spio_pkg::*;
#(
    parameter int DW = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq,
    input  logic [DW-1:0]     pa_in,
    output logic [DW-1:0]     pa_out,
    output logic [DW-1:0]     pa_oe,
    input  logic              sa_in,
    output logic              sa_out,
    output logic              sa_oe,
    input  logic [DW-1:0]     pb_in,
    output logic [DW-1:0]     pb_out,
    output logic [DW-1:0]     pb_oe,
    input  logic              sb_in,
    output logic              sb_out,
    output logic              sb_oe
);
    logic [CFG_W-1:0] cfg_q;
    logic [NPORT-1:0] ien_q;
    logic [NPORT-1:0] flags;
    logic [NPORT-1:0] cap;
    logic [NPORT-1:0] clr_rd;
    logic [NPORT-1:0] clr_wr;
    logic [NPORT-1:0] wr_lat;

    port_cfg_t        pcfg   [NPORT];
    logic [DW-1:0]    pin_i  [NPORT];
    logic [DW-1:0]    pin_o  [NPORT];
    logic [DW-1:0]    pin_oe [NPORT];
    logic [DW-1:0]    lat_q  [NPORT];
    logic             stb_i  [NPORT];
    logic             stb_o  [NPORT];
    logic             stb_oe [NPORT];

    // Bus registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ien_q <= '0;
        end else if (wr_en) begin
            if (addr == RA_CFG) cfg_q <= wdata[CFG_W-1:0] & CFG_MASK;
            if (addr == RA_IEN) ien_q <= wdata[NPORT-1:0];
        end
    end

    // Per-port configuration fields
    assign pcfg[0] = '{dir: cfg_q[CFG_DIR_A], od: cfg_q[CFG_OD_A], pol: cfg_q[CFG_POL_A]};
    assign pcfg[1] = '{dir: cfg_q[CFG_DIR_B], od: cfg_q[CFG_OD_B], pol: cfg_q[CFG_POL_B]};

    assign pin_i[0] = pa_in;
    assign pin_i[1] = pb_in;
    assign stb_i[0] = sa_in;
    assign stb_i[1] = sb_in;

    assign wr_lat[0] = wr_en && (addr == RA_LAT_A);
    assign wr_lat[1] = wr_en && (addr == RA_LAT_B);
    assign clr_rd[0] = rd_en && (addr == RA_LAT_A);
    assign clr_rd[1] = rd_en && (addr == RA_LAT_B);
    assign clr_wr    = (wr_en && (addr == RA_STAT)) ? wdata[NPORT-1:0] : '0;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        spio_port #(.DW(DW)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg    (pcfg[g]),
            .wr_lat (wr_lat[g]),
            .wdata  (wdata),
            .pin_i  (pin_i[g]),
            .stb_i  (stb_i[g]),
            .lat_q  (lat_q[g]),
            .pin_o  (pin_o[g]),
            .pin_oe (pin_oe[g]),
            .stb_o  (stb_o[g]),
            .stb_oe (stb_oe[g]),
            .cap_o  (cap[g])
        );
    end

    spio_irq #(.NP(NPORT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mode (cfg_q[CFG_CLRMODE]),
        .set      (cap),
        .clr_rd   (clr_rd),
        .clr_wr   (clr_wr),
        .ien      (ien_q),
        .flags    (flags),
        .irq      (irq)
    );

    assign pa_out = pin_o[0];
    assign pa_oe  = pin_oe[0];
    assign sa_out = stb_o[0];
    assign sa_oe  = stb_oe[0];
    assign pb_out = pin_o[1];
    assign pb_oe  = pin_oe[1];
    assign sb_out = stb_o[1];
    assign sb_oe  = stb_oe[1];

    // Read multiplexer
    always_comb begin
        unique case (addr)
            RA_CFG:   rdata = DW'(cfg_q);
            RA_IEN:   rdata = DW'(ien_q);
            RA_STAT:  rdata = DW'(flags);
            RA_LAT_A: rdata = lat_q[0];
            RA_LAT_B: rdata = lat_q[1];
            RA_PIN_A: rdata = pa_in;
            RA_PIN_B: rdata = pb_in;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/spio_chk.sv
module spio_chk #(
    parameter int DW = 8,
    parameter int AW = 3
)(
    input logic          clk,
    input logic          rst_n,
    input logic          dir_a,
    input logic          od_a,
    input logic          pol_a,
    input logic          clr_mode,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wdata0,
    input logic [DW-1:0] lat_a,
    input logic [DW-1:0] pa_in,
    input logic [DW-1:0] pa_out,
    input logic [DW-1:0] pa_oe,
    input logic          sa_out,
    input logic          sa_oe,
    input logic          flag_a
);
    localparam logic [AW-1:0] A_STAT  = AW'(2);
    localparam logic [AW-1:0] A_LAT_A = AW'(3);

    p_pushpull_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_a && !od_a) |-> (pa_oe == '1 && pa_out == lat_a));

    p_opendrain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_a && od_a) |-> (pa_out == '0 && (pa_oe & lat_a) == '0 && (pa_oe | lat_a) == '1));

    p_input_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_a |-> (pa_oe == '0 && !sa_oe));

    p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_oe && sa_out == pol_a) |-> $past(wr_en && addr == A_LAT_A));

    p_capture_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> (lat_a == $past(pa_in)));

    // Covers R9 (clear on read) and R10 (clear on status write).
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_a) |-> ($past(clr_mode) ? $past(wr_en && addr == A_STAT && wdata0)
                                           : $past(rd_en && addr == A_LAT_A)));
endmodule

bind strobed_pio spio_chk #(.DW(DW), .AW(spio_pkg::REG_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_a    (cfg_q[spio_pkg::CFG_DIR_A]),
    .od_a     (cfg_q[spio_pkg::CFG_OD_A]),
    .pol_a    (cfg_q[spio_pkg::CFG_POL_A]),
    .clr_mode (cfg_q[spio_pkg::CFG_CLRMODE]),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata0   (wdata[0]),
    .lat_a    (lat_q[0]),
    .pa_in    (pa_in),
    .pa_out   (pa_out),
    .pa_oe    (pa_oe),
    .sa_out   (sa_out),
    .sa_oe    (sa_oe),
    .flag_a   (flags[0])
);

// File: tb/strobed_pio_tb.sv
`timescale 1ns/1ps
module strobed_pio_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    logic [DW-1:0] pa_in = '0, pa_out, pa_oe;
    logic          sa_in = 1'b0, sa_out, sa_oe;
    logic [DW-1:0] pb_in = '0, pb_out, pb_oe;
    logic          sb_in = 1'b0, sb_out, sb_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    strobed_pio #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .sa_in(sa_in), .sa_out(sa_out), .sa_oe(sa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .sb_in(sb_in), .sb_out(sb_out), .sb_oe(sb_oe)
    );

    // Signal selectors for the scoreboard
    localparam int S_RDATA = 0, S_PAOUT = 1, S_PAOE = 2, S_SAOUT = 3,
                   S_SAOE = 4, S_IRQ = 5;

    typedef struct {
        string        tag;
        int           sel;
        logic [7:0]   exp;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    logic [7:0] act;

    function automatic logic [7:0] pick(int sel);
        case (sel)
            S_RDATA: return rdata;
            S_PAOUT: return pa_out;
            S_PAOE:  return pa_oe;
            S_SAOUT: return {7'd0, sa_out};
            S_SAOE:  return {7'd0, sa_oe};
            default: return {7'd0, irq};
        endcase
    endfunction

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            cur = q.pop_front();
            act = pick(cur.sel);
            checks++;
            if (act !== cur.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", cur.tag, act, cur.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(string tag, int sel, logic [7:0] e);
        q.push_back('{tag: tag, sel: sel, exp: e});
    endtask

    // Wait for the monitor to sample, then let one edge pass.
    task automatic flush();
        wait (q.size() == 0);
        @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] a, logic [7:0] e, string tag);
        addr  = a;
        rd_en = 1'b1;
        push(tag, S_RDATA, e);
        flush();
        rd_en = 1'b0;
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cyc();

        // R1 reset state; R4 input mode after reset
        push("R1 irq after reset", S_IRQ, 8'h00);
        push("R4 pin enables after reset", S_PAOE, 8'h00);
        push("R4 strobe enable after reset", S_SAOE, 8'h00);
        rd_chk(3'd0, 8'h00, "R1 cfg reset");
        bus_wr(3'd0, 8'hFF);
        rd_chk(3'd0, 8'hBF, "R1 cfg readback reserved bit");
        bus_wr(3'd0, 8'h00);

        // R2 push-pull output; R5 active-low pulse
        bus_wr(3'd0, 8'h08);
        bus_wr(3'd3, 8'hA5);
        push("R2 pa_out", S_PAOUT, 8'hA5);
        push("R2 pa_oe", S_PAOE, 8'hFF);
        push("R5 strobe oe", S_SAOE, 8'h01);
        push("R5 low pulse active", S_SAOUT, 8'h00);
        flush();
        push("R5 low pulse ended", S_SAOUT, 8'h01);
        flush();

        // R5 active-high pulse
        bus_wr(3'd0, 8'h0A);
        bus_wr(3'd3, 8'h3C);
        push("R5 high pulse active", S_SAOUT, 8'h01);
        flush();
        push("R5 high pulse ended", S_SAOUT, 8'h00);
        flush();

        // R3 open-drain
        bus_wr(3'd0, 8'h28);
        push("R3 pa_out zero", S_PAOUT, 8'h00);
        push("R3 pa_oe inverse", S_PAOE, 8'hC3);
        flush();

        // R7 pin registers in output mode and input mode
        pa_in = 8'h77;
        pb_in = 8'h12;
        rd_chk(3'd5, 8'h77, "R7 pins A");
        rd_chk(3'd6, 8'h12, "R7 pins B");

        // R6 capture timing, R8 flag and irq, R9 read clear
        bus_wr(3'd1, 8'h01);
        bus_wr(3'd0, 8'h00);
        pa_in = 8'hC6;
        sa_in = 1'b1;
        cycles(2);
        push("R8 irq before capture", S_IRQ, 8'h00);
        rd_chk(3'd3, 8'h3C, "R6 latch holds before third edge");
        push("R8 irq after capture", S_IRQ, 8'h01);
        rd_chk(3'd2, 8'h01, "R8 flag A set");
        bus_wr(3'd2, 8'h01);
        rd_chk(3'd2, 8'h01, "R9 status write ignored");
        rd_chk(3'd3, 8'hC6, "R6 captured A");
        rd_chk(3'd2, 8'h00, "R9 read cleared flag");
        push("R8 irq cleared", S_IRQ, 8'h00);
        flush();

        // R10 write-to-clear mode
        bus_wr(3'd0, 8'h80);
        sa_in = 1'b0;
        cycles(4);
        pa_in = 8'h5E;
        sa_in = 1'b1;
        cycles(4);
        rd_chk(3'd3, 8'h5E, "R6 second capture A");
        rd_chk(3'd2, 8'h01, "R10 read did not clear");
        bus_wr(3'd2, 8'h00);
        rd_chk(3'd2, 8'h01, "R10 zero bit keeps flag");
        bus_wr(3'd2, 8'h01);
        rd_chk(3'd2, 8'h00, "R10 write cleared flag");

        // R11 polarity rewrite makes an edge on port B; R8 masking
        pb_in = 8'h99;
        bus_wr(3'd0, 8'h81);
        cyc();
        rd_chk(3'd2, 8'h02, "R11 polarity change set flag B");
        push("R8 masked irq", S_IRQ, 8'h00);
        flush();
        bus_wr(3'd1, 8'h03);
        push("R8 enabled irq", S_IRQ, 8'h01);
        flush();
        rd_chk(3'd4, 8'h99, "R11 latch B captured");

        // R6 active-high polarity: capture on falling pin
        sb_in = 1'b1;
        cycles(4);
        pb_in = 8'h81;
        sb_in = 1'b0;
        cycles(4);
        rd_chk(3'd4, 8'h81, "R6 capture on falling strobe");
        bus_wr(3'd2, 8'h03);
        rd_chk(3'd2, 8'h00, "R10 both flags cleared");

        // R11 direction change to input makes an edge on port A
        bus_wr(3'd0, 8'h88);
        cycles(2);
        rd_chk(3'd2, 8'h00, "R11 output mode no flag");
        pa_in = 8'h44;
        bus_wr(3'd0, 8'h80);
        cyc();
        rd_chk(3'd2, 8'h01, "R11 direction change set flag A");
        rd_chk(3'd3, 8'h44, "R11 latch A captured");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule